// File: doc/BRIEF.md
# Sticky Event Flag Register with Read-Arm Clear

This block holds one sticky flag per channel for a set of hardware event sources. A one-cycle pulse on a channel's event input raises that channel's flag, and the flag stays up until software clears it. Clearing takes two bus accesses. Software first reads the register, which arms every flag it saw as set. It then writes zero to the bits it wants to drop. An event that lands between the read and the write disarms its channel, so the write leaves that flag standing and no interrupt is lost.

The register sits at a single address on a plain strobe bus. The bus has a read strobe, a write strobe and full-width write data. Read data is registered and is valid in the cycle after the read strobe. The low bits carry the flags and the upper bits always read as zero. Each flag is also brought out on its own output for use outside the block. Each channel has an interrupt enable input, and its interrupt request is the flag gated by that enable.

Top module: `evflag_regs`

## Requirements
- R1: After synchronous reset every flag, every interrupt request and the read data are 0.
- R2: An event pulse on channel i sets flag i on the next clock edge, and the flag stays set until it is cleared as described in R4.
- R3: The read data in the cycle after a read strobe carries flag i in bit i for i = 0..7, as sampled at the strobe edge. Bits 31 to 8 read as zero, including after writes of all ones.
- R4: A write strobe with data bit i = 0 clears flag i when an earlier read returned bit i as 1, and no event has reached channel i since that read.
- R5: A write of 0 to bit i leaves flag i set when no read has returned it as 1 since the last clear. A completed clear also uses up the arming, so a second zero write needs a new read first.
- R6: Writing 1 to bit i changes neither flag i nor its armed state. A later zero write, with no new read in between, still clears a flag that was armed before the write of 1.
- R7: An event on channel i after the arming read and before the zero write cancels the clear. The flag stays set, and a further zero write with no new read also leaves it set.
- R8: An event on channel i in the same cycle as a clearing write keeps flag i set.
- R9: After one read, a single write of 0x00000000 clears every flag that the read returned as 1. Flags first set after that read stay set.
- R10: flag_view mirrors the flags. irq_req[i] is flag i AND irq_enable[i], and it follows changes of the enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 8 | One bit per channel; high for a cycle when that channel's event occurs |
| irq_enable | input | 8 | Per-channel interrupt enable |
| bus_rd | input | 1 | Read strobe for the flag register |
| bus_wr | input | 1 | Write strobe for the flag register |
| bus_wdata | input | 32 | Write data; a 0 in bit i asks to clear flag i |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| flag_view | output | 8 | Current value of every flag |
| irq_req | output | 8 | Per-channel interrupt request |

## Verification
The bench builds the block with its default parameters: eight channels and a 32-bit data word. That width makes the upper 24 read-as-zero bits observable, and it lets a single write carry a zero in one flag bit and ones in the others. Using eight channels lets one register access hit channels in different states at once: armed, armed and then hit again by an event, and never read. This exercises the mixed cases of R6, R7 and R9 in the same write.

// File: rtl/evflag_pkg.sv
package evflag_pkg;

    // Request seen by one channel in one cycle
    typedef struct packed {
        logic evt;   // hardware event on this channel
        logic rd;    // register read strobe
        logic wr;    // register write strobe
        logic wbit;  // this channel's bit of the write data
    } ch_req_t;

    // Stored state of one channel
    typedef struct packed {
        logic flag;
        logic armed;
    } ch_state_t;

    localparam ch_state_t CH_IDLE = '{flag: 1'b0, armed: 1'b0};

    // A clear happens only on an armed zero write with no event racing it
    function automatic logic clear_fires(ch_req_t r, ch_state_t s);
        return r.wr & s.armed & ~r.wbit & ~r.evt;
    endfunction

    function automatic ch_state_t step(ch_req_t r, ch_state_t s);
        ch_state_t n;
        logic      clr;
        clr = clear_fires(r, s);
        n   = s;
        if (r.evt) begin
            n.flag  = 1'b1;
            n.armed = 1'b0;
        end else if (clr) begin
            n.flag  = 1'b0;
            n.armed = 1'b0;
        end else if (r.rd && s.flag) begin
            n.armed = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/evflag_cell.sv
module evflag_cell
    import evflag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic flag,
    output logic armed
);

    ch_req_t   req;
    ch_state_t cur_q;
    ch_state_t nxt;

    always_comb begin
        req.evt  = evt;
        req.rd   = rd;
        req.wr   = wr;
        req.wbit = wbit;
        nxt      = step(req, cur_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= CH_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    assign flag  = cur_q.flag;
    assign armed = cur_q.armed;

endmodule

// File: rtl/evflag_rdport.sv
module evflag_rdport #(
    parameter int N_CH   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [N_CH-1:0]   flags,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - N_CH;

    logic [DATA_W-1:0] word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, flags};
        end else begin : g_nopad
            assign word = flags[DATA_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= word;
        end
    end

endmodule

// File: rtl/evflag_regs.sv
module evflag_regs #(
    parameter int N_CH   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   evt_pulse,
    input  logic [N_CH-1:0]   irq_enable,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   flag_view,
    output logic [N_CH-1:0]   irq_req
);

    logic [N_CH-1:0] flag_w;
    logic [N_CH-1:0] armed_w;

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            evflag_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .evt   (evt_pulse[i]),
                .rd    (bus_rd),
                .wr    (bus_wr),
                .wbit  (bus_wdata[i]),
                .flag  (flag_w[i]),
                .armed (armed_w[i])
            );
        end
    endgenerate

    evflag_rdport #(
        .N_CH   (N_CH),
        .DATA_W (DATA_W)
    ) u_rdport (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .flags (flag_w),
        .rdata (bus_rdata)
    );

    assign flag_view = flag_w;
    assign irq_req   = flag_w & irq_enable;

endmodule

// File: rtl/evflag_chk.sv
module evflag_chk #(
    parameter int N_CH   = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CH-1:0]   evt_pulse,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_CH-1:0]   flag_view
);

    assert_rdata_R3: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd) |-> bus_rdata[N_CH-1:0] == $past(flag_view));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata >> N_CH) == '0);

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_p
            assert_set_R2: assert property (@(posedge clk) disable iff (rst)
                evt_pulse[i] |=> flag_view[i]);

            assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
                (flag_view[i] && !(bus_wr && !bus_wdata[i])) |=> flag_view[i]);

            assert_race_R8: assert property (@(posedge clk) disable iff (rst)
                $fell(flag_view[i]) |-> $past(bus_wr && !bus_wdata[i] && !evt_pulse[i]));
        end
    endgenerate

endmodule

bind evflag_regs evflag_chk #(
    .N_CH   (N_CH),
    .DATA_W (DATA_W)
) u_evflag_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flag_view (flag_view)
);

// File: tb/test_evflag_regs.sv
module test_evflag_regs;

    localparam int N_CH   = 8;
    localparam int DATA_W = 32;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } rd_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_CH-1:0]   evt_pulse = '0;
    logic [N_CH-1:0]   irq_enable = 8'hA5;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [N_CH-1:0]   flag_view;
    logic [N_CH-1:0]   irq_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    rd_item_t sb_q[$];
    logic rd_pend = 1'b0;

    always #5 clk = ~clk;

    evflag_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) i_evflag_regs (
        .clk        (clk),
        .rst        (rst),
        .evt_pulse  (evt_pulse),
        .irq_enable (irq_enable),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .flag_view  (flag_view),
        .irq_req    (irq_req)
    );

    // Monitor: read data is due the cycle after the strobe
    always @(posedge clk) rd_pend <= bus_rd & ~rst;

    always @(negedge clk) begin
        if (rd_pend) begin
            rd_item_t it;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected read response %h", "R3", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic check8(input string tag, input logic [N_CH-1:0] act,
                          input logic [N_CH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus/event cycle, starting and ending at a falling edge
    task automatic cyc(input logic [N_CH-1:0] ev, input logic rd, input logic wr,
                       input logic [DATA_W-1:0] wd);
        evt_pulse = ev;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_wdata = wd;
        @(negedge clk);
        evt_pulse = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_expect(input logic [DATA_W-1:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        cyc('0, 1'b1, 1'b0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            if (sb_q.size() != 0) begin
                checks++;
                errors++;
                $display("FAIL R3: %0d read responses missing, expected 0", sb_q.size());
            end
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check8("R1 flags", flag_view, 8'h00);
        check8("R1 irq", irq_req, 8'h00);
        checks++;
        if (bus_rdata !== '0) begin
            errors++;
            $display("FAIL R1: rdata actual %h expected 0", bus_rdata);
        end
        rd_expect(32'h0, "R1/R3 read after reset");

        // R2 set and sticky, R10 irq gating
        cyc(8'h81, 1'b0, 1'b0, '0);
        check8("R2 set", flag_view, 8'h81);
        check8("R10 irq", irq_req, 8'h81);
        cyc('0, 1'b0, 1'b0, '0);
        cyc('0, 1'b0, 1'b0, '0);
        check8("R2 sticky", flag_view, 8'h81);

        // R5 zero write without arming read
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R5 unarmed write", flag_view, 8'h81);

        // R4 clear bit 7, R6 bit 0 written as 1 stays
        rd_expect(32'h81, "R3 read 81");
        cyc('0, 1'b0, 1'b1, 32'hFFFF_FF7F);
        check8("R4/R6 partial clear", flag_view, 8'h01);
        // R6 arming survived the write of 1
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R6 arm kept", flag_view, 8'h00);
        // R5 completed clear used up arming
        cyc(8'h01, 1'b0, 1'b0, '0);
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R5 arm consumed", flag_view, 8'h01);
        rd_expect(32'h01, "R3 read 01");
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R4 clear", flag_view, 8'h00);

        // R7 event between read and write
        cyc(8'h04, 1'b0, 1'b0, '0);
        rd_expect(32'h04, "R7 arming read");
        cyc(8'h04, 1'b0, 1'b0, '0);
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R7 race kept", flag_view, 8'h04);
        check8("R7 irq kept", irq_req, 8'h04);
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R7 no re-arm", flag_view, 8'h04);
        rd_expect(32'h04, "R7 reread");
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R7 later clear", flag_view, 8'h00);

        // R8 event in the same cycle as the clearing write
        cyc(8'h10, 1'b0, 1'b0, '0);
        rd_expect(32'h10, "R8 arming read");
        cyc(8'h10, 1'b0, 1'b1, 32'h0);
        check8("R8 same-cycle event", flag_view, 8'h10);
        rd_expect(32'h10, "R8 reread");
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R8 later clear", flag_view, 8'h00);

        // R9 bulk clear spares flags set after the read
        cyc(8'h0F, 1'b0, 1'b0, '0);
        rd_expect(32'h0F, "R9 bulk read");
        cyc(8'h30, 1'b0, 1'b0, '0);
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R9 bulk clear", flag_view, 8'h30);
        rd_expect(32'h30, "R9 reread");
        cyc('0, 1'b0, 1'b1, 32'h0);
        check8("R9 second clear", flag_view, 8'h00);

        // R10 enable gating follows enable immediately
        cyc(8'hFF, 1'b0, 1'b0, '0);
        irq_enable = 8'h3C;
        #1;
        check8("R10 irq mask 3C", irq_req, 8'h3C);
        irq_enable = 8'h00;
        #1;
        check8("R10 irq mask 00", irq_req, 8'h00);
        check8("R10 flag mirror", flag_view, 8'hFF);
        irq_enable = 8'hA5;
        @(negedge clk);

        // R3 upper bits ignore writes; R6 all ones changes nothing
        cyc('0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        check8("R6 write ones", flag_view, 8'hFF);
        rd_expect(32'h0000_00FF, "R3 upper zero");
        cyc('0, 1'b0, 1'b1, 32'hFFFF_FF00);
        check8("R9 clear all", flag_view, 8'h00);
        rd_expect(32'h0, "R3 final read");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule